// File: doc/BRIEF.md
# Affinity-Routed Software Interrupt Target Decoder

This block turns one 64-bit software-interrupt generation write into a delivery vector across a set of processors. Each processor is known by a 32-bit affinity address built from four bytes, level 3 in the most significant byte down to level 0 in the least. The block splits the write into its fields. It compares every processor's affinity against those fields in parallel. One cycle after the write it presents the set of processors that must receive the interrupt, along with the 4-bit interrupt number.

The write carries a routing-mode flag. In broadcast mode, every implemented processor except the one that issued the write is targeted. In list mode, a 16-entry target list is applied inside the cluster named by the upper three affinity levels. A 4-bit range selector moves the list's base in steps of 16 level-0 values. A range-support input says whether that selector is honoured. Targets that no implemented processor answers to produce no delivery.

The processor affinities arrive as strap inputs. The issuing processor is given as an index into the same processor array. Security grouping, pending-state storage and the register access path sit outside this block.

Top module: `sgi_affinity_decoder`

## Requirements
- R1: One clock after a cycle with `wr_valid_i` high, `dlv_valid_o` is 1 and `dlv_intid_o` equals bits [27:24] of that write.
- R2: In list mode (write bit 40 = 0), processor p is delivered to exactly when three conditions all hold. First, its level-3 byte equals write bits [55:48]. Second, its level-2 byte equals bits [39:32]. Third, its level-1 byte equals bits [23:16], and target-list bit k of bits [15:0] is set, where k is its level-0 value minus 16 times the effective range selector.
- R3: The range selector in write bits [47:44] maps target-list bit n to level-0 value RS*16+n when `rs_support_i` is 1.
- R4: When `rs_support_i` is 0, the range selector is treated as 0, so only processors with level-0 values 0 to 15 can be reached in list mode.
- R5: In broadcast mode (write bit 40 = 1), every implemented processor except the one indexed by `wr_src_i` is delivered to, whatever the affinity fields and target list hold.
- R6: In list mode, the issuing processor is delivered to when its own affinity matches the write.
- R7: A write whose fields name no implemented processor still gives `dlv_valid_o` = 1, with an all-zero `dlv_mask_o`.
- R8: After reset, and in any cycle that follows a cycle without a write, `dlv_valid_o` and `dlv_mask_o` are 0.
- R9: Bits [31:24], [23:16], [15:8] and [7:0] of each 32-bit slice of `pe_aff_i` are taken as affinity levels 3, 2, 1 and 0 of that processor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | A generation write is present this cycle |
| wr_data_i | input | 64 | Generation write value |
| wr_src_i | input | SRC_W | Index of the issuing processor |
| rs_support_i | input | 1 | 1 = range selector honoured, 0 = forced to zero |
| pe_aff_i | input | NUM_PE*32 | Affinity of each processor, processor 0 in the low slice |
| dlv_valid_o | output | 1 | Delivery result valid |
| dlv_mask_o | output | NUM_PE | One bit per processor to be interrupted |
| dlv_intid_o | output | 4 | Interrupt number of the delivery |

## Verification
The processors are strapped so that they differ one level at a time: four share a cluster with low level-0 values, two sit above level-0 value 15, and the others differ only in level 1 or level 3. Single-bit and multi-bit lists within the cluster show whether the level-0 indexing is right. Writes that name a neighbouring cluster show whether each upper level is compared on its own. The same range-selected list is sent with range support on and then off, to tell honouring the selector apart from forcing it to zero. Broadcasts from two different issuers, with list mode aimed at the issuer and a write that names nothing, separate exclusion of self from plain matching.

// File: rtl/sgi_dec_pkg.sv
package sgi_dec_pkg;

    // write field positions (behavioural: software encodes these)
    localparam int AFF3_LSB   = 48;
    localparam int RS_LSB     = 44;
    localparam int MODE_BIT   = 40;
    localparam int AFF2_LSB   = 32;
    localparam int INTID_LSB  = 24;
    localparam int AFF1_LSB   = 16;
    localparam int TLIST_LSB  = 0;

    localparam int AFF_W      = 8;
    localparam int RS_W       = 4;
    localparam int INTID_W    = 4;
    localparam int TLIST_W    = 16;
    localparam int PE_AFF_W   = 4 * AFF_W;

    typedef enum logic {
        ROUTE_LIST  = 1'b0,
        ROUTE_OTHERS = 1'b1
    } route_mode_e;

    typedef struct packed {
        logic [AFF_W-1:0]   aff3;
        logic [AFF_W-1:0]   aff2;
        logic [AFF_W-1:0]   aff1;
        logic [RS_W-1:0]    rsel;
        route_mode_e        mode;
        logic [INTID_W-1:0] intid;
        logic [TLIST_W-1:0] tlist;
    } sgi_req_t;

    typedef struct packed {
        logic [AFF_W-1:0] lvl3;
        logic [AFF_W-1:0] lvl2;
        logic [AFF_W-1:0] lvl1;
        logic [AFF_W-1:0] lvl0;
    } pe_aff_t;

    function automatic sgi_req_t split_write(input logic [63:0] w);
        sgi_req_t r;
        r.aff3  = w[AFF3_LSB  +: AFF_W];
        r.aff2  = w[AFF2_LSB  +: AFF_W];
        r.aff1  = w[AFF1_LSB  +: AFF_W];
        r.rsel  = w[RS_LSB    +: RS_W];
        r.mode  = route_mode_e'(w[MODE_BIT]);
        r.intid = w[INTID_LSB +: INTID_W];
        r.tlist = w[TLIST_LSB +: TLIST_W];
        return r;
    endfunction

    function automatic pe_aff_t unpack_aff(input logic [PE_AFF_W-1:0] a);
        pe_aff_t p;
        p.lvl3 = a[31:24];
        p.lvl2 = a[23:16];
        p.lvl1 = a[15:8];
        p.lvl0 = a[7:0];
        return p;
    endfunction

endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
    import sgi_dec_pkg::*;
(
    input  logic [63:0] wr_data_i,
    input  logic        rs_support_i,
    output sgi_req_t    req_o
);
    sgi_req_t raw;

    always_comb begin
        raw   = split_write(wr_data_i);
        req_o = raw;
        // narrow-range parts: selector forced to the first group of 16
        if (!rs_support_i) begin
            req_o.rsel = '0;
        end
    end
endmodule

// File: rtl/sgi_pe_match.sv
module sgi_pe_match
    import sgi_dec_pkg::*;
(
    input  sgi_req_t              req_i,
    input  logic [PE_AFF_W-1:0]   aff_i,
    input  logic                  is_src_i,
    output logic                  hit_o
);
    pe_aff_t aff;
    logic    cluster_eq;
    logic    group_eq;
    logic    list_bit;

    always_comb begin
        aff        = unpack_aff(aff_i);
        cluster_eq = (aff.lvl3 == req_i.aff3) &&
                     (aff.lvl2 == req_i.aff2) &&
                     (aff.lvl1 == req_i.aff1);
        group_eq   = (aff.lvl0[7:4] == req_i.rsel);
        list_bit   = req_i.tlist[aff.lvl0[3:0]];
        unique case (req_i.mode)
            ROUTE_OTHERS: hit_o = !is_src_i;
            ROUTE_LIST:   hit_o = cluster_eq && group_eq && list_bit;
            default:      hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sgi_affinity_decoder.sv
module sgi_affinity_decoder
    import sgi_dec_pkg::*;
#(
    parameter  int NUM_PE = 8,
    localparam int SRC_W  = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_valid_i,
    input  logic [63:0]              wr_data_i,
    input  logic [SRC_W-1:0]         wr_src_i,
    input  logic                     rs_support_i,
    input  logic [NUM_PE*32-1:0]     pe_aff_i,
    output logic                     dlv_valid_o,
    output logic [NUM_PE-1:0]        dlv_mask_o,
    output logic [INTID_W-1:0]       dlv_intid_o
);
    sgi_req_t          req;
    logic [NUM_PE-1:0] hit;
    logic [NUM_PE-1:0] high_lvl0;

    sgi_req_decode u_decode (
        .wr_data_i    (wr_data_i),
        .rs_support_i (rs_support_i),
        .req_o        (req)
    );

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        sgi_pe_match u_match (
            .req_i    (req),
            .aff_i    (pe_aff_i[p*PE_AFF_W +: PE_AFF_W]),
            .is_src_i (wr_src_i == SRC_W'(p)),
            .hit_o    (hit[p])
        );
        // processors unreachable without range support (checker aid)
        assign high_lvl0[p] = |pe_aff_i[p*PE_AFF_W+4 +: 4];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dlv_valid_o <= 1'b0;
            dlv_mask_o  <= '0;
            dlv_intid_o <= '0;
        end else begin
            dlv_valid_o <= wr_valid_i;
            dlv_mask_o  <= wr_valid_i ? hit : '0;
            dlv_intid_o <= wr_valid_i ? req.intid : '0;
        end
    end

    // R1
    intid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dlv_valid_o |-> dlv_intid_o == $past(wr_data_i[INTID_LSB +: INTID_W]));

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid_i |=> dlv_valid_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dlv_valid_o |-> dlv_mask_o == '0);

    // R5
    bcast_self_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid_o && $past(wr_data_i[MODE_BIT])) |->
            !dlv_mask_o[$past(wr_src_i)]);

    // R5
    bcast_count_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid_o && $past(wr_data_i[MODE_BIT]) && ($past(wr_src_i) < NUM_PE)) |->
            $countones(dlv_mask_o) == NUM_PE - 1);

    // R4
    narrow_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dlv_valid_o && !$past(wr_data_i[MODE_BIT]) && !$past(rs_support_i)) |->
            (dlv_mask_o & $past(high_lvl0)) == '0);

endmodule

// File: tb/test_sgi_affinity_decoder.sv
module test_sgi_affinity_decoder;
    localparam int NUM_PE = 8;
    localparam int SRC_W  = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_valid_i = 1'b0;
    logic [63:0]          wr_data_i = '0;
    logic [SRC_W-1:0]     wr_src_i = '0;
    logic                 rs_support_i = 1'b1;
    logic [NUM_PE*32-1:0] pe_aff_i;
    logic                 dlv_valid_o;
    logic [NUM_PE-1:0]    dlv_mask_o;
    logic [3:0]           dlv_intid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;   // 250 MHz

    // strapped affinities {lvl3, lvl2, lvl1, lvl0}
    assign pe_aff_i = {
        32'h05_02_03_01,   // PE7: other level 3
        32'h01_02_04_00,   // PE6: other level 1
        32'h01_02_03_25,   // PE5: level 0 = 0x25
        32'h01_02_03_11,   // PE4: level 0 = 0x11
        32'h01_02_03_03,   // PE3
        32'h01_02_03_02,   // PE2
        32'h01_02_03_01,   // PE1
        32'h01_02_03_00    // PE0
    };

    sgi_affinity_decoder #(.NUM_PE(NUM_PE)) i_sgi_affinity_decoder (
        .clk, .rst, .wr_valid_i, .wr_data_i, .wr_src_i, .rs_support_i,
        .pe_aff_i, .dlv_valid_o, .dlv_mask_o, .dlv_intid_o
    );

    function automatic logic [63:0] mk(input logic [7:0] a3, input logic [7:0] a2,
                                       input logic [7:0] a1, input logic [3:0] rs,
                                       input logic irm, input logic [3:0] id,
                                       input logic [15:0] tl);
        return {8'h00, a3, rs, 3'b000, irm, a2, 4'h0, id, a1, tl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one write at a falling edge, sample one cycle later
    task automatic send(input logic [63:0] d, input logic [2:0] src, input logic rss);
        @(negedge clk);
        wr_valid_i   = 1'b1;
        wr_data_i    = d;
        wr_src_i     = src;
        rs_support_i = rss;
        @(negedge clk);
        wr_valid_i   = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8 reset valid", {31'b0, dlv_valid_o}, 32'd0);
        check("R8 reset mask", {24'b0, dlv_mask_o}, 32'd0);
    endtask

    task automatic t_list_basic();
        send(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h5, 16'h000F), 3'd6, 1'b1);
        check("R1 valid", {31'b0, dlv_valid_o}, 32'd1);
        check("R1 intid", {28'b0, dlv_intid_o}, 32'd5);
        check("R2 R9 list 0xF", {24'b0, dlv_mask_o}, 32'h0F);
        send(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h9, 16'h0005), 3'd6, 1'b1);
        check("R2 list 0x5", {24'b0, dlv_mask_o}, 32'h05);
        check("R1 intid 9", {28'b0, dlv_intid_o}, 32'd9);
    endtask

    task automatic t_range();
        send(mk(8'h01, 8'h02, 8'h03, 4'h1, 1'b0, 4'h2, 16'h0002), 3'd0, 1'b1);
        check("R3 rs=1 bit1", {24'b0, dlv_mask_o}, 32'h10);
        send(mk(8'h01, 8'h02, 8'h03, 4'h2, 1'b0, 4'h2, 16'h0020), 3'd0, 1'b1);
        check("R3 rs=2 bit5", {24'b0, dlv_mask_o}, 32'h20);
    endtask

    task automatic t_narrow();
        send(mk(8'h01, 8'h02, 8'h03, 4'h1, 1'b0, 4'h3, 16'h0002), 3'd0, 1'b0);
        check("R4 rs forced 0", {24'b0, dlv_mask_o}, 32'h02);
        send(mk(8'h01, 8'h02, 8'h03, 4'h2, 1'b0, 4'h3, 16'h0020), 3'd0, 1'b0);
        check("R4 high lvl0 unreachable", {24'b0, dlv_mask_o}, 32'h00);
    endtask

    task automatic t_bcast();
        send(mk(8'hAA, 8'hBB, 8'hCC, 4'h7, 1'b1, 4'hF, 16'h0000), 3'd2, 1'b1);
        check("R5 others from 2", {24'b0, dlv_mask_o}, 32'hFB);
        check("R1 intid F", {28'b0, dlv_intid_o}, 32'hF);
        send(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b1, 4'h1, 16'hFFFF), 3'd7, 1'b0);
        check("R5 others from 7", {24'b0, dlv_mask_o}, 32'h7F);
    endtask

    task automatic t_self();
        send(mk(8'h01, 8'h02, 8'h03, 4'h0, 1'b0, 4'h4, 16'h0001), 3'd0, 1'b1);
        check("R6 issuer targeted", {24'b0, dlv_mask_o}, 32'h01);
    endtask

    task automatic t_levels();
        send(mk(8'h01, 8'h02, 8'h04, 4'h0, 1'b0, 4'h6, 16'h0001), 3'd0, 1'b1);
        check("R9 level1 cluster", {24'b0, dlv_mask_o}, 32'h40);
        send(mk(8'h05, 8'h02, 8'h03, 4'h0, 1'b0, 4'h6, 16'h0002), 3'd0, 1'b1);
        check("R9 level3 cluster", {24'b0, dlv_mask_o}, 32'h80);
    endtask

    task automatic t_nothing();
        send(mk(8'h01, 8'h02, 8'h09, 4'h0, 1'b0, 4'h8, 16'hFFFF), 3'd1, 1'b1);
        check("R7 valid", {31'b0, dlv_valid_o}, 32'd1);
        check("R7 empty mask", {24'b0, dlv_mask_o}, 32'h00);
        @(negedge clk);
        check("R8 idle valid", {31'b0, dlv_valid_o}, 32'd0);
        check("R8 idle mask", {24'b0, dlv_mask_o}, 32'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_list_basic();
                t_range();
                t_narrow();
                t_bcast();
                t_self();
                t_levels();
                t_nothing();
                done = 1;
            end
            begin
                repeat (5000) @(negedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual hung expected done");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule